// File: doc/BRIEF.md
# Boot Flash Write-Protect Control Register

This block is one 8-bit control and status register that decides whether host writes may reach the boot flash. A host port with a register select, a write strobe and byte data updates it, and its full image is always visible on the read-data port. A write-enable bit drives the write-permit output seen by the flash access path. A lock bit, once set, cannot be cleared by software. While the lock is set, every write that raises the write-enable bit from 0 to 1 produces a one-cycle trap request. The system management handler can then inspect the change and revert it, so only trusted code can open the flash for writing.

Two more fields pass through the register. A 2-bit read-policy field goes to the flash read cache; its two bits are prefetch enable and cache disable. A read-only bit mirrors an external top-swap status input after a parameterised synchroniser. The access path also supplies a flag for a write aimed at the secondary feature-space range. Writes to that range are always permitted, whatever the write-enable bit holds. The platform reset clears every stored field, including the lock.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While and after platform reset (rst_n low), the stored fields are zero. With swap_status held 0, reg_rdata reads 8'h00, flash_wr_permit is 0, trap_pulse is 0 and rd_policy is 2'b00.
- R2: Bit 0 of the register is the write-enable bit. A write stores reg_wdata[0] in it, and flash_wr_permit is 1 when that bit is 1.
- R3: Bit 1 is the lock bit. A write with reg_wdata[1]=1 sets it. A write with reg_wdata[1]=0 leaves it unchanged. Only rst_n low clears it.
- R4: When a write finds bit 0 at 0 and bit 1 already at 1, and reg_wdata[0]=1, trap_pulse is high for exactly the one cycle after that write's clock edge.
- R5: No trap is raised by a write that leaves bit 0 at 1 when it was already 1. No trap is raised by a single write that sets bit 0 and bit 1 together from a state with bit 1 clear.
- R6: Bits 3:2 form a read/write policy field driven on rd_policy. Bit 3 is prefetch enable and appears on rd_policy[1]. Bit 2 is cache disable and appears on rd_policy[0].
- R7: Bit 4 is read-only. It follows swap_status after SWAP_SYNC clock edges (default 2), and writes to bit 4 have no effect.
- R8: Bits 7:5 always read as zero, even after a write of ones.
- R9: When wr_aux_range is 1, flash_wr_permit is 1 even while bit 0 is 0.
- R10: With reg_sel at 0, a pulse on reg_wr changes no field and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, taken when reg_sel is high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register image |
| swap_status | input | 1 | External top-swap status |
| wr_aux_range | input | 1 | Current flash write targets the feature-space range |
| flash_wr_permit | output | 1 | Writes to the boot flash allowed |
| trap_pulse | output | 1 | One-cycle trap request |
| rd_policy | output | 2 | Read-cache policy: [1] prefetch, [0] cache disable |

## Verification
The setting of the lock bit and the trap decision can fall on the same clock edge. This happens when one write carries both bit 0 and bit 1 set. The bench provokes this straight after a reset and expects trap_pulse to stay low, because the decision uses the lock value from before the write. A later write that clears bit 0 and then sets it again must trap, which shows that the lock was in fact stored by that combined write.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned BIT_WE   = 0;
   localparam int unsigned BIT_LOCK = 1;
   localparam int unsigned BIT_CD   = 2;
   localparam int unsigned BIT_PF   = 3;
   localparam int unsigned BIT_SWAP = 4;
   localparam int unsigned POL_W    = BIT_PF - BIT_CD + 1;

   typedef struct packed {
      logic [POL_W-1:0] pol;
      logic             lock;
      logic             we;
   } wp_fields_t;
endpackage

// File: rtl/wp_field_regs.sv
module wp_field_regs
   import flash_wp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [REG_W-1:0] wdata,
   output wp_fields_t       cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (wr_stb) begin
         cur.we   <= wdata[BIT_WE];
         cur.lock <= cur.lock | wdata[BIT_LOCK];
         cur.pol  <= wdata[BIT_PF:BIT_CD];
      end
   end
endmodule

// File: rtl/wp_trap_gen.sv
module wp_trap_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic new_we,
   input  logic old_we,
   input  logic old_lock,
   output logic trap
);
   logic fire;
   assign fire = wr_stb & new_we & ~old_we & old_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trap <= 1'b0;
      else        trap <= fire;
   end
endmodule

// File: rtl/wp_sync.sv
module wp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2+((STAGES==1)?1:0):0] & {(STAGES>1?STAGES-1:1){STAGES>1}}, din} [STAGES-1:0];
         end
         assign dout = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
   import flash_wp_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SWAP_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              swap_status,
   input  logic              wr_aux_range,
   output logic              flash_wr_permit,
   output logic              trap_pulse,
   output logic [1:0]        rd_policy
);
   localparam int unsigned RSV_LO = BIT_SWAP + 1;

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("flash_wp_ctrl: DATA_W must equal REG_W");
      end
      if (SWAP_SYNC > 4) begin : g_bad_sync
         $error("flash_wp_ctrl: SWAP_SYNC above 4 is not supported");
      end
   endgenerate

   logic       wr_stb;
   wp_fields_t cur;
   logic       swap_q;

   assign wr_stb = reg_sel & reg_wr;

   wp_field_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(wr_stb),
      .wdata (reg_wdata[REG_W-1:0]),
      .cur   (cur)
   );

   wp_trap_gen u_trap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .new_we  (reg_wdata[BIT_WE]),
      .old_we  (cur.we),
      .old_lock(cur.lock),
      .trap    (trap_pulse)
   );

   wp_sync #(.STAGES(SWAP_SYNC)) u_swap (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (swap_status),
      .dout (swap_q)
   );

   always_comb begin
      reg_rdata                     = '0;
      reg_rdata[BIT_WE]             = cur.we;
      reg_rdata[BIT_LOCK]           = cur.lock;
      reg_rdata[BIT_PF:BIT_CD]      = cur.pol;
      reg_rdata[BIT_SWAP]           = swap_q;
      reg_rdata[DATA_W-1:RSV_LO]    = '0;
   end

   assign flash_wr_permit = cur.we | wr_aux_range;
   assign rd_policy       = cur.pol;
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_sel,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       wr_aux_range,
   input logic       flash_wr_permit,
   input logic       trap_pulse
);
   a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rdata[1]) |-> reg_rdata[1])
      else $error("R3 lock bit cleared without reset");

   a_r4_trap_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> $past(reg_rdata[1]) && !$past(reg_rdata[0]) && reg_rdata[0])
      else $error("R4 trap without locked 0-to-1 write enable");

   a_r4_trap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |=> !trap_pulse)
      else $error("R4 trap wider than one cycle");

   a_r2_permit_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[0] && !wr_aux_range) |-> !flash_wr_permit)
      else $error("R2 permit without write enable");

   a_r10_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_sel && rst_n) |=> (reg_rdata[3:0] == $past(reg_rdata[3:0])) && !trap_pulse)
      else $error("R10 unselected cycle changed state");

   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_wr && reg_wdata[7:5] != 3'b000) |=> reg_rdata[7:5] == 3'b000)
      else $error("R8 reserved bits nonzero");
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_sel        (reg_sel),
   .reg_wr         (reg_wr),
   .reg_wdata      (reg_wdata),
   .reg_rdata      (reg_rdata),
   .wr_aux_range   (wr_aux_range),
   .flash_wr_permit(flash_wr_permit),
   .trap_pulse     (trap_pulse)
);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       swap_status = 1'b0;
   logic       wr_aux_range = 1'b0;
   logic       flash_wr_permit;
   logic       trap_pulse;
   logic [1:0] rd_policy;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_wp_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .swap_status(swap_status),
      .wr_aux_range(wr_aux_range), .flash_wr_permit(flash_wr_permit),
      .trap_pulse(trap_pulse), .rd_policy(rd_policy)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // write on one edge; trap is sampled just after that edge, then one cycle later
   task automatic wr(input logic [7:0] d, input logic sel, input logic exp_trap, input string req);
      @(negedge clk);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      @(posedge clk); #1;
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
      chk(req, {7'd0, trap_pulse}, {7'd0, exp_trap});
      @(posedge clk); #1;
      chk({req, " pulse end"}, {7'd0, trap_pulse}, 8'h00);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R1 rdata", reg_rdata, 8'h00);
      chk("R1 permit/trap/policy", {4'd0, flash_wr_permit, trap_pulse, rd_policy}, 8'h00);
   endtask

   task automatic t_we_unlocked();
      wr(8'h01, 1'b1, 1'b0, "R5 unlocked set no trap");
      chk("R2 we readback", reg_rdata, 8'h01);
      chk("R2 permit open", {7'd0, flash_wr_permit}, 8'h01);
      wr(8'h00, 1'b1, 1'b0, "R2 clear");
      chk("R2 permit closed", {7'd0, flash_wr_permit}, 8'h00);
   endtask

   task automatic t_policy_reserved();
      wr(8'hE8, 1'b1, 1'b0, "R6 write");
      chk("R6 policy prefetch", {6'd0, rd_policy}, 8'h02);
      chk("R8 reserved and swap ignore", reg_rdata, 8'h08);
      wr(8'h04, 1'b1, 1'b0, "R6 write cd");
      chk("R6 policy cache disable", {6'd0, rd_policy}, 8'h01);
      wr(8'h00, 1'b1, 1'b0, "R6 clear");
   endtask

   task automatic t_swap();
      @(negedge clk); swap_status = 1'b1;
      @(posedge clk); #1;
      chk("R7 swap after 1 edge", {7'd0, reg_rdata[4]}, 8'h00);
      @(posedge clk); #1;
      chk("R7 swap after 2 edges", {7'd0, reg_rdata[4]}, 8'h01);
      wr(8'h00, 1'b1, 1'b0, "R7 write zero");
      chk("R7 write ignored", {7'd0, reg_rdata[4]}, 8'h01);
      @(negedge clk); swap_status = 1'b0;
      repeat (2) @(posedge clk); #1;
      chk("R7 swap low", {7'd0, reg_rdata[4]}, 8'h00);
   endtask

   task automatic t_lock_trap();
      wr(8'h02, 1'b1, 1'b0, "R3 set lock");
      chk("R3 lock set", reg_rdata, 8'h02);
      wr(8'h00, 1'b1, 1'b0, "R3 clear attempt");
      chk("R3 lock kept", reg_rdata, 8'h02);
      wr(8'h01, 1'b0, 1'b0, "R10 unselected no trap");
      chk("R10 unselected no change", reg_rdata, 8'h02);
      wr(8'h01, 1'b1, 1'b1, "R4 locked rise traps");
      chk("R4 we stored", reg_rdata, 8'h03);
      wr(8'h01, 1'b1, 1'b0, "R5 stays one no trap");
      wr(8'h00, 1'b1, 1'b0, "R4 drop");
      wr(8'h01, 1'b1, 1'b1, "R4 second rise traps");
   endtask

   task automatic t_aux_and_reset_lock();
      wr(8'h00, 1'b1, 1'b0, "R9 close");
      @(negedge clk); wr_aux_range = 1'b1; #1;
      chk("R9 aux permit", {7'd0, flash_wr_permit}, 8'h01);
      @(negedge clk); wr_aux_range = 1'b0; #1;
      chk("R9 aux off", {7'd0, flash_wr_permit}, 8'h00);
      do_reset(); #1;
      chk("R3 reset clears lock", reg_rdata, 8'h00);
   endtask

   task automatic t_combined();
      do_reset();
      wr(8'h03, 1'b1, 1'b0, "R5 combined no trap");
      chk("R5 combined stored", reg_rdata, 8'h03);
      wr(8'h02, 1'b1, 1'b0, "R5 drop");
      wr(8'h03, 1'b1, 1'b1, "R4 trap after combined lock");
   endtask

   initial begin
      t_reset();
      t_we_unlocked();
      t_policy_reserved();
      t_swap();
      t_lock_trap();
      t_aux_and_reset_lock();
      t_combined();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule